// File: doc/BRIEF.md
# Dual-Path DSL Downstream Superframe Multiplexer

This block assembles the downstream byte framing of a DSL transmitter. Three byte-wide user channels enter through valid/ready handshakes: a high-rate simplex channel (48 bytes per frame), a low-rate control channel (one byte every second frame) and a duplex channel (5 bytes per frame). The simplex and control channels go to the interleaved-latency path. The duplex channel goes to the fast-latency path. Each path leaves the block as its own byte stream, one byte per clock.

A free-running timer divides time into frames of 52 byte slots. Frames are grouped into a superframe of 68 frames, numbered 0 to 67. The first slot of every frame holds an overhead byte. In frame 0 this byte is the CRC supplied on an input port. In frames 1, 34 and 35 it is an indicator byte. Every other frame, including the closing sync frame 67, carries a fixed idle value, because no operations channel is carried. The block never stalls: a channel that is not ready with data is replaced by a fill byte, and an underrun pulse is raised. The later stages (scrambling, CRC calculation, FEC, interleaving) sit outside the block.

Top module: `adsl_sf_mux`

## Requirements
- R1: After reset the frame counter starts at frame 0, slot 0. Each frame lasts 52 cycles. The counter runs 0..67 and wraps to 0. `frame_num` gives the frame of the byte currently on the outputs, one cycle after the slot is decoded.
- R2: Interleaved path layout: slot 0 is the overhead byte, slots 1..48 are simplex bytes in arrival order, slot 49 is the control slot, slot 50 is the AEX byte 0x00 and slot 51 is the LEX byte 0xA5. `il_vld` is high on every cycle after reset, and `il_sof` marks slot 0.
- R3: Fast path layout: slot 0 is the overhead byte, slots 1..5 are duplex bytes in arrival order and slot 6 is the LEX byte 0xA5. `fast_vld` is high only in slots 0..6, and `fast_byte` is 0x00 in slots 7..51. `fast_sof` marks slot 0.
- R4: The control slot accepts a byte only in even-numbered frames. In odd frames `ls0_ready` stays low and the slot carries 0x55.
- R5: In frame 0, slot 0 carries `crc_il` on the interleaved path and `crc_fast` on the fast path, with each value taken in the cycle that slot is decoded.
- R6: Slot 0 of frames 1, 34 and 35 carries indicator bits [7:0], [15:8] and [23:16] respectively, taken from `ind_il` and `ind_fast`.
- R7: Slot 0 of every other frame, frame 67 included, carries the idle overhead value 0x3C.
- R8: In frame 67 all ready outputs stay low, data and control slots carry 0x00, and no underrun is flagged.
- R9: If a channel is not valid in a slot where its ready is high, the slot carries 0x00 and that channel's underrun output is high for exactly that byte's cycle. Frame timing continues unchanged.
- R10: Each ready output is high only in that channel's own slots. During reset all ready, valid and start outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| as0_data | input | 8 | Simplex channel byte |
| as0_valid | input | 1 | Simplex byte present |
| as0_ready | output | 1 | Simplex byte taken this cycle if valid |
| ls0_data | input | 8 | Control channel byte |
| ls0_valid | input | 1 | Control byte present |
| ls0_ready | output | 1 | Control byte taken this cycle if valid |
| ls1_data | input | 8 | Duplex channel byte |
| ls1_valid | input | 1 | Duplex byte present |
| ls1_ready | output | 1 | Duplex byte taken this cycle if valid |
| crc_il | input | 8 | CRC byte for the interleaved path |
| crc_fast | input | 8 | CRC byte for the fast path |
| ind_il | input | 24 | Indicator bits, interleaved path |
| ind_fast | input | 24 | Indicator bits, fast path |
| il_byte | output | 8 | Interleaved path byte |
| il_vld | output | 1 | Interleaved byte valid |
| il_sof | output | 1 | Interleaved frame start |
| fast_byte | output | 8 | Fast path byte |
| fast_vld | output | 1 | Fast byte valid |
| fast_sof | output | 1 | Fast frame start |
| frame_num | output | 7 | Frame number of the output byte |
| as0_urun | output | 1 | Simplex underrun pulse |
| ls0_urun | output | 1 | Control underrun pulse |
| ls1_urun | output | 1 | Duplex underrun pulse |

## Verification
The bench checks every output byte of three full superframes against a slot-by-slot model. It targets the boundaries that are easy to get off by one: the frame 67 to frame 0 wrap, the slot 48/49/50 edges and the end of the fast frame at slot 6. An off-by-one here would show up as a lost or duplicated data byte, or a mistimed `fast_vld`. The CRC inputs change on every cycle, so a design that samples them one cycle late would put the wrong CRC byte in frame 0. A design that mixed up the indicator frames would put the wrong byte lane in frames 1, 34 or 35. The second superframe withholds data in irregular patterns. A design that stalled, duplicated or skipped bytes would break the arrival order. One that flagged underruns in odd control frames or in the sync frame would raise a pulse where none belongs.

// File: rtl/adsl_sf_pkg.sv
// Package: shared types and fixed byte values for the superframe multiplexer.
// Assumes: byte-wide channels; the fill values below are defined by the block's requirements.
package adsl_sf_pkg;

    typedef enum logic [2:0] {
        OVH_CRC  = 3'd0,
        OVH_IND0 = 3'd1,
        OVH_IND1 = 3'd2,
        OVH_IND2 = 3'd3,
        OVH_IDLE = 3'd4
    } ovh_kind_e;

    localparam logic [7:0] EOC_IDLE_BYTE = 8'h3C;
    localparam logic [7:0] DATA_FILL     = 8'h00;
    localparam logic [7:0] CTRL_IDLE     = 8'h55;
    localparam logic [7:0] AEX_BYTE      = 8'h00;
    localparam logic [7:0] LEX_BYTE      = 8'hA5;

endpackage

// File: rtl/adsl_sf_timer.sv
// Module: superframe timer. Counts byte slots within a frame and frames within
// a superframe. Also decodes which kind of overhead byte the current frame carries.
// Assumes: N_FRAMES >= 4 and even, FRAME_LEN >= 2; free-running, never stalls.
module adsl_sf_timer
    import adsl_sf_pkg::*;
#(
    parameter int N_FRAMES  = 68,
    parameter int FRAME_LEN = 52,
    parameter int FR_W      = $clog2(N_FRAMES),
    parameter int IDX_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [FR_W-1:0]  frame_cnt,
    output logic [IDX_W-1:0] byte_idx,
    output logic             last_frame,
    output logic             even_frame,
    output ovh_kind_e        ovh_kind
);

    localparam logic [FR_W-1:0]  LAST_FR  = FR_W'(N_FRAMES - 1);
    localparam logic [FR_W-1:0]  IND1_FR  = FR_W'(N_FRAMES / 2);
    localparam logic [FR_W-1:0]  IND2_FR  = FR_W'(N_FRAMES / 2 + 1);
    localparam logic [FR_W-1:0]  IND0_FR  = FR_W'(1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    // Advance the slot index and step the frame counter at the end of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt <= '0;
            byte_idx  <= '0;
        end else if (byte_idx == LAST_IDX) begin
            byte_idx  <= '0;
            frame_cnt <= (frame_cnt == LAST_FR) ? '0 : frame_cnt + 1'b1;
        end else begin
            byte_idx  <= byte_idx + 1'b1;
        end
    end

    // Decode the frame role: the sync frame, frame parity and the overhead byte kind.
    always_comb begin
        last_frame = (frame_cnt == LAST_FR);
        even_frame = ~frame_cnt[0];
        if (frame_cnt == '0)          ovh_kind = OVH_CRC;
        else if (frame_cnt == IND0_FR) ovh_kind = OVH_IND0;
        else if (frame_cnt == IND1_FR) ovh_kind = OVH_IND1;
        else if (frame_cnt == IND2_FR) ovh_kind = OVH_IND2;
        else                           ovh_kind = OVH_IDLE;
    end

    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt == LAST_FR && byte_idx == LAST_IDX) |=> (frame_cnt == '0 && byte_idx == '0));

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_idx <= LAST_IDX);

    // R1
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_idx != LAST_IDX) |=> $stable(frame_cnt));

endmodule

// File: rtl/adsl_path_framer.sv
// Module: one latency path's frame assembler. Places an overhead byte, DATA_N
// channel bytes, an optional control slot with AEX byte, and a LEX byte.
// The output is registered and runs one cycle behind the slot index.
// Assumes: the slot index comes from adsl_sf_timer. PATH_LEN <= the frame length.
// A missing byte never stalls the path: it is replaced by fill.
module adsl_path_framer
    import adsl_sf_pkg::*;
#(
    parameter int DATA_N  = 48,
    parameter bit CTRL_EN = 1'b1,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic             last_frame,
    input  logic             even_frame,
    input  ovh_kind_e        ovh_kind,
    input  logic [7:0]       crc_in,
    input  logic [23:0]      ind_in,
    input  logic [7:0]       ch_data,
    input  logic             ch_valid,
    output logic             ch_ready,
    input  logic [7:0]       ctrl_data,
    input  logic             ctrl_valid,
    output logic             ctrl_ready,
    output logic [7:0]       out_byte,
    output logic             out_vld,
    output logic             out_sof,
    output logic             urun_data,
    output logic             urun_ctrl
);

    localparam int PATH_LEN = DATA_N + 2 + (CTRL_EN ? 2 : 0);
    localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_N);
    localparam logic [IDX_W-1:0] CTRL_IDX  = IDX_W'(DATA_N + 1);
    localparam logic [IDX_W-1:0] AEX_IDX   = IDX_W'(DATA_N + 2);
    localparam logic [IDX_W-1:0] LEX_IDX   = IDX_W'(PATH_LEN - 1);

    logic [7:0] nxt_byte;
    logic       in_data_slot;

    // Data slots span slot 1 to DATA_N, and no data is taken in the sync frame.
    always_comb begin
        in_data_slot = (byte_idx != '0) && (byte_idx <= DATA_LAST);
        ch_ready     = in_data_slot && !last_frame;
    end

    // Control slot exists only when enabled, and it is open in even, non-sync frames.
    generate
        if (CTRL_EN) begin : g_ctrl
            assign ctrl_ready = (byte_idx == CTRL_IDX) && !last_frame && even_frame;
        end else begin : g_noctrl
            assign ctrl_ready = 1'b0;
        end
    endgenerate

    // Select the byte for the current slot.
    always_comb begin
        if (byte_idx == '0) begin
            unique case (ovh_kind)
                OVH_CRC:  nxt_byte = crc_in;
                OVH_IND0: nxt_byte = ind_in[7:0];
                OVH_IND1: nxt_byte = ind_in[15:8];
                OVH_IND2: nxt_byte = ind_in[23:16];
                default:  nxt_byte = EOC_IDLE_BYTE;
            endcase
        end else if (in_data_slot) begin
            nxt_byte = (ch_ready && ch_valid) ? ch_data : DATA_FILL;
        end else if (CTRL_EN && byte_idx == CTRL_IDX) begin
            if (ctrl_ready) nxt_byte = ctrl_valid ? ctrl_data : DATA_FILL;
            else if (last_frame) nxt_byte = DATA_FILL;
            else nxt_byte = CTRL_IDLE;
        end else if (CTRL_EN && byte_idx == AEX_IDX) begin
            nxt_byte = AEX_BYTE;
        end else if (byte_idx == LEX_IDX) begin
            nxt_byte = LEX_BYTE;
        end else begin
            nxt_byte = 8'h00;
        end
    end

    // Register the path output and the underrun pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte  <= 8'h00;
            out_vld   <= 1'b0;
            out_sof   <= 1'b0;
            urun_data <= 1'b0;
            urun_ctrl <= 1'b0;
        end else begin
            out_byte  <= nxt_byte;
            out_vld   <= (byte_idx <= LEX_IDX);
            out_sof   <= (byte_idx == '0);
            urun_data <= ch_ready && !ch_valid;
            urun_ctrl <= ctrl_ready && !ctrl_valid;
        end
    end

    // R8
    sync_frame_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_frame |-> (!ch_ready && !ctrl_ready));

    // R9
    urun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        urun_data |-> $past(ch_ready && !ch_valid));

    // R2
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ready && ch_valid) |=> (out_byte == $past(ch_data)));

    // R4
    ctrl_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_ready |-> even_frame);

endmodule

// File: rtl/adsl_sf_mux.sv
// Module: top of the dual-path superframe multiplexer. One shared timer drives
// an interleaved-path framer (simplex data plus control slot) and a fast-path
// framer (duplex data). The frame number is registered alongside the output bytes.
// Assumes: the interleaved frame is the longer one and sets the frame period.
module adsl_sf_mux
    import adsl_sf_pkg::*;
#(
    parameter int N_FRAMES = 68,
    parameter int AS_N     = 48,
    parameter int LS1_N    = 5,
    parameter int FR_W     = $clog2(N_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       as0_data,
    input  logic             as0_valid,
    output logic             as0_ready,
    input  logic [7:0]       ls0_data,
    input  logic             ls0_valid,
    output logic             ls0_ready,
    input  logic [7:0]       ls1_data,
    input  logic             ls1_valid,
    output logic             ls1_ready,
    input  logic [7:0]       crc_il,
    input  logic [7:0]       crc_fast,
    input  logic [23:0]      ind_il,
    input  logic [23:0]      ind_fast,
    output logic [7:0]       il_byte,
    output logic             il_vld,
    output logic             il_sof,
    output logic [7:0]       fast_byte,
    output logic             fast_vld,
    output logic             fast_sof,
    output logic [FR_W-1:0]  frame_num,
    output logic             as0_urun,
    output logic             ls0_urun,
    output logic             ls1_urun
);

    localparam int IL_LEN    = AS_N + 4;
    localparam int IDX_W     = $clog2(IL_LEN);

    logic [FR_W-1:0]  frame_cnt;
    logic [IDX_W-1:0] byte_idx;
    logic             last_frame;
    logic             even_frame;
    ovh_kind_e        ovh_kind;
    logic             il_ctrl_ready, fast_ctrl_ready;
    logic             il_ctrl_urun, fast_ctrl_urun;

    adsl_sf_timer #(
        .N_FRAMES (N_FRAMES),
        .FRAME_LEN(IL_LEN),
        .FR_W     (FR_W),
        .IDX_W    (IDX_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_cnt (frame_cnt),
        .byte_idx  (byte_idx),
        .last_frame(last_frame),
        .even_frame(even_frame),
        .ovh_kind  (ovh_kind)
    );

    adsl_path_framer #(
        .DATA_N (AS_N),
        .CTRL_EN(1'b1),
        .IDX_W  (IDX_W)
    ) u_il (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_idx  (byte_idx),
        .last_frame(last_frame),
        .even_frame(even_frame),
        .ovh_kind  (ovh_kind),
        .crc_in    (crc_il),
        .ind_in    (ind_il),
        .ch_data   (as0_data),
        .ch_valid  (as0_valid),
        .ch_ready  (as0_ready),
        .ctrl_data (ls0_data),
        .ctrl_valid(ls0_valid),
        .ctrl_ready(il_ctrl_ready),
        .out_byte  (il_byte),
        .out_vld   (il_vld),
        .out_sof   (il_sof),
        .urun_data (as0_urun),
        .urun_ctrl (il_ctrl_urun)
    );

    adsl_path_framer #(
        .DATA_N (LS1_N),
        .CTRL_EN(1'b0),
        .IDX_W  (IDX_W)
    ) u_fast (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_idx  (byte_idx),
        .last_frame(last_frame),
        .even_frame(even_frame),
        .ovh_kind  (ovh_kind),
        .crc_in    (crc_fast),
        .ind_in    (ind_fast),
        .ch_data   (ls1_data),
        .ch_valid  (ls1_valid),
        .ch_ready  (ls1_ready),
        .ctrl_data (8'h00),
        .ctrl_valid(1'b0),
        .ctrl_ready(fast_ctrl_ready),
        .out_byte  (fast_byte),
        .out_vld   (fast_vld),
        .out_sof   (fast_sof),
        .urun_data (ls1_urun),
        .urun_ctrl (fast_ctrl_urun)
    );

    // The control channel is served by the interleaved framer only. The fast framer's terms are zero.
    always_comb begin
        ls0_ready = il_ctrl_ready | fast_ctrl_ready;
        ls0_urun  = il_ctrl_urun | fast_ctrl_urun;
    end

    // Align the reported frame number with the registered output bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_num <= '0;
        else        frame_num <= frame_cnt;
    end

    // R2
    il_vld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        il_vld |=> il_vld);

    // R3
    path_sof_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        il_sof == fast_sof);

    // R3
    fast_vld_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_sof |-> fast_vld);

endmodule

// File: tb/adsl_sf_mux_tb.sv
// Bench: sweeps three full superframes slot by slot. Expected bytes, ready
// levels and underrun pulses come from a slot model of the requirements.
module adsl_sf_mux_tb;

    localparam int NF  = 68;
    localparam int LEN = 52;
    localparam int SF_CYC = NF * LEN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  as0_data = 8'h00, ls0_data = 8'h00, ls1_data = 8'h00;
    logic        as0_valid = 1'b0, ls0_valid = 1'b0, ls1_valid = 1'b0;
    logic        as0_ready, ls0_ready, ls1_ready;
    logic [7:0]  crc_il = 8'h00, crc_fast = 8'h00;
    logic [23:0] ind_il = 24'h0, ind_fast = 24'h0;
    logic [7:0]  il_byte, fast_byte;
    logic        il_vld, il_sof, fast_vld, fast_sof;
    logic [6:0]  frame_num;
    logic        as0_urun, ls0_urun, ls1_urun;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    adsl_sf_mux u_dut (
        .clk(clk), .rst_n(rst_n),
        .as0_data(as0_data), .as0_valid(as0_valid), .as0_ready(as0_ready),
        .ls0_data(ls0_data), .ls0_valid(ls0_valid), .ls0_ready(ls0_ready),
        .ls1_data(ls1_data), .ls1_valid(ls1_valid), .ls1_ready(ls1_ready),
        .crc_il(crc_il), .crc_fast(crc_fast), .ind_il(ind_il), .ind_fast(ind_fast),
        .il_byte(il_byte), .il_vld(il_vld), .il_sof(il_sof),
        .fast_byte(fast_byte), .fast_vld(fast_vld), .fast_sof(fast_sof),
        .frame_num(frame_num),
        .as0_urun(as0_urun), .ls0_urun(ls0_urun), .ls1_urun(ls1_urun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Overhead byte by frame number (R5, R6, R7).
    function automatic logic [7:0] ovh_exp(input int f, input logic [7:0] crc, input logic [23:0] ind);
        if (f == 0)       return crc;
        else if (f == 1)  return ind[7:0];
        else if (f == 34) return ind[15:8];
        else if (f == 35) return ind[23:16];
        else              return 8'h3C;
    endfunction

    function automatic logic [7:0] nxt_seq(input logic [7:0] s);
        return (s == 8'hFF) ? 8'h01 : s + 8'h01;
    endfunction

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int mf = 0;
        int mi = 0;
        logic [7:0] as_seq = 8'h01, ls0_seq = 8'h01, ls1_seq = 8'h01;
        logic [7:0] e_il, e_fast;
        logic e_asr, e_l0r, e_l1r, e_asu, e_l0u, e_l1u;

        // R10: reset state
        repeat (4) @(posedge clk);
        #1;
        chk("R10 reset il_vld", il_vld, 0);
        chk("R10 reset fast_vld", fast_vld, 0);
        chk("R10 reset il_sof", il_sof, 0);
        chk("R10 reset as0_ready", as0_ready, 0);
        chk("R10 reset ls1_ready", ls1_ready, 0);
        chk("R10 reset ls0_ready", ls0_ready, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 3 * SF_CYC; cyc++) begin
            int sf;
            if (cyc != 0) @(negedge clk);
            sf = cyc / SF_CYC;
            // Stimulus: superframe 1 withholds data in irregular patterns.
            if (sf == 1) begin
                as0_valid = cyc[0];
                ls1_valid = (cyc % 3) != 0;
                ls0_valid = 1'b0;
            end else begin
                as0_valid = 1'b1;
                ls1_valid = 1'b1;
                ls0_valid = 1'b1;
            end
            as0_data = as_seq;
            ls0_data = ls0_seq;
            ls1_data = ls1_seq;
            crc_il   = cyc[7:0] ^ 8'h5A;
            crc_fast = cyc[7:0];
            ind_il   = 24'h123456 + 24'(sf);
            ind_fast = 24'hABCDEF ^ 24'(sf);

            e_asr = (mi >= 1) && (mi <= 48) && (mf != 67);
            e_l1r = (mi >= 1) && (mi <= 5) && (mf != 67);
            e_l0r = (mi == 49) && (mf != 67) && (mf % 2 == 0);
            // R10 R4 R8: ready levels
            chk("R10 as0_ready", as0_ready, e_asr);
            chk("R10 ls1_ready", ls1_ready, e_l1r);
            chk("R4 ls0_ready", ls0_ready, e_l0r);

            // Expected interleaved byte (R2, R4, R5..R9).
            if (mi == 0) e_il = ovh_exp(mf, crc_il, ind_il);
            else if (mi <= 48) e_il = (e_asr && as0_valid) ? as_seq : 8'h00;
            else if (mi == 49) e_il = e_l0r ? (ls0_valid ? ls0_seq : 8'h00) : (mf == 67 ? 8'h00 : 8'h55);
            else if (mi == 50) e_il = 8'h00;
            else e_il = 8'hA5;
            // Expected fast byte (R3, R5..R9).
            if (mi == 0) e_fast = ovh_exp(mf, crc_fast, ind_fast);
            else if (mi <= 5) e_fast = (e_l1r && ls1_valid) ? ls1_seq : 8'h00;
            else if (mi == 6) e_fast = 8'hA5;
            else e_fast = 8'h00;
            e_asu = e_asr && !as0_valid;
            e_l0u = e_l0r && !ls0_valid;
            e_l1u = e_l1r && !ls1_valid;

            @(posedge clk);
            #1;
            chk("R1 frame_num", frame_num, mf);
            chk("R2 il_vld", il_vld, 1);
            chk("R2 il_sof", il_sof, mi == 0);
            if (mi == 0 && mf == 0) chk("R5 il crc byte", il_byte, e_il);
            else if (mi == 0 && (mf == 1 || mf == 34 || mf == 35)) chk("R6 il indicator", il_byte, e_il);
            else if (mi == 0) chk("R7 il idle overhead", il_byte, e_il);
            else if (mf == 67) chk("R8 il sync frame byte", il_byte, e_il);
            else if (mi == 49) chk("R4 il control slot", il_byte, e_il);
            else chk("R2 il byte", il_byte, e_il);
            chk("R3 fast_vld", fast_vld, mi < 7);
            chk("R3 fast_sof", fast_sof, mi == 0);
            if (mi == 0 && mf == 0) chk("R5 fast crc byte", fast_byte, e_fast);
            else if (mi == 0 && (mf == 1 || mf == 34 || mf == 35)) chk("R6 fast indicator", fast_byte, e_fast);
            else if (mi == 0) chk("R7 fast idle overhead", fast_byte, e_fast);
            else chk("R3 fast byte", fast_byte, e_fast);
            chk("R9 as0_urun", as0_urun, e_asu);
            chk("R9 ls0_urun", ls0_urun, e_l0u);
            chk("R9 ls1_urun", ls1_urun, e_l1u);

            if (e_asr && as0_valid) as_seq = nxt_seq(as_seq);
            if (e_l0r && ls0_valid) ls0_seq = nxt_seq(ls0_seq);
            if (e_l1r && ls1_valid) ls1_seq = nxt_seq(ls1_seq);
            if (mi == LEN - 1) begin
                mi = 0;
                mf = (mf == NF - 1) ? 0 : mf + 1;
            end else begin
                mi = mi + 1;
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule